// File: doc/BRIEF.md
# Physical Register Rename Unit

This block maps the architectural registers of an in-order instruction stream onto a larger pool of physical registers. It holds three pieces of state. The alias table records, for each architectural register, whether a physical register currently stands for it. The free pool is a first-in first-out queue of unallocated physical tags. The committed register file holds the only official register values.

Each rename slot presents two source register IDs, a destination register ID and a flag saying whether a destination is written. For each source the block reports either the physical tag that will produce the value or, when no mapping exists, the committed value itself. The destination receives the tag at the head of the free pool. A retire port writes a result into the committed file and always returns the retiring tag to the free pool. It clears the alias entry only when that entry still names the retiring tag. When the pool is empty, rename stalls through a not-ready output.

In a cycle that has both a rename and a retirement, the retirement is applied first. The rename then sees the retired value and the cleared mapping. The freed tag becomes allocatable in the following cycle.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset every alias entry is unmapped, every committed register reads 0, ready_o is 1, and the pool holds tags 0 to 15 in ascending order, so the first allocations return tags 0, 1, 2, ...
- R2: Each accepted rename with dst_en_i=1 returns dst_tag_o equal to the tag at the head of the free pool, and pops it.
- R3: Sources are looked up before the destination mapping of the same instruction is written. A source equal to the destination sees the older mapping. A mapped source reports src_*_mapped_o=1 and the producing tag on src_*_tag_o.
- R4: An unmapped source reports src_*_mapped_o=0 and src_*_data_o equal to the committed register value.
- R5: A retirement writes ret_data_i into committed register ret_arch_i. A later rename reading that register while it is unmapped sees the value.
- R6: A retirement whose tag matches the current alias entry of ret_arch_i resets that entry to unmapped.
- R7: A retirement whose tag differs from the alias entry of ret_arch_i, because a younger writer remapped it, leaves the entry unchanged.
- R8: Every retired tag is appended to the tail of the free pool, whatever the alias outcome. It can be allocated from the cycle after the retirement at the earliest.
- R9: When the free pool is empty, ready_o is 0 and a presented rename allocates nothing and changes no mapping.
- R10: In a cycle with both a retirement and a rename, the rename's source lookups see the alias entry already cleared and the committed value already written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | 1 | Rename request present |
| ren_ready_o | output | 1 | Free pool not empty; rename accepted when valid and ready |
| ren_src_a_i | input | 3 | First source architectural register |
| ren_src_b_i | input | 3 | Second source architectural register |
| ren_dst_i | input | 3 | Destination architectural register |
| ren_dst_en_i | input | 1 | Instruction writes a destination |
| src_a_mapped_o | output | 1 | First source is produced by a physical register |
| src_a_tag_o | output | 4 | Producing tag of first source |
| src_a_data_o | output | 32 | Committed value of first source |
| src_b_mapped_o | output | 1 | Second source is produced by a physical register |
| src_b_tag_o | output | 4 | Producing tag of second source |
| src_b_data_o | output | 32 | Committed value of second source |
| dst_tag_o | output | 4 | Tag allocated to the destination |
| ret_valid_i | input | 1 | Retirement present |
| ret_arch_i | input | 3 | Architectural destination of the retiring instruction |
| ret_tag_i | input | 4 | Physical tag of the retiring instruction |
| ret_data_i | input | 32 | Result being committed |

## Verification
The bench first targets the alias-clear decision. A design that cleared on every retirement would make a source read a stale committed value while a younger writer is still in flight. A design that never cleared would leave sources waiting on a recycled tag. It also drains the pool to empty and holds a rename there, where a faulty stall would hand out a tag twice. It then frees one tag and checks that the tag reappears only on the following cycle, behind the older free entries. Same-cycle retire and rename checks the forwarding of the committed value and of the cleared entry, which a design without bypass gets one cycle late. Random in-order traffic against a reference model covers source-equals-destination lookups.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned ARCH_REGS = 6;
  localparam int unsigned PHYS_REGS = 16;
  localparam int unsigned XLEN      = 32;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned TW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [TW-1:0] push_tag_i,
  output logic [TW-1:0] head_tag_o,
  output logic          empty_o
);
  logic [TW-1:0] fifo_q [NUM_PHYS];
  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] p);
    return (p == TW'(NUM_PHYS - 1)) ? '0 : p + TW'(1);
  endfunction

  assign head_tag_o = fifo_q[head_q];
  assign empty_o    = (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) fifo_q[i] <= TW'(i);
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(NUM_PHYS);
    end else begin
      if (push_i) begin
        fifo_q[tail_q] <= push_tag_i;
        tail_q         <= wrap_inc(tail_q);
      end
      if (pop_i) head_q <= wrap_inc(head_q);
      if (push_i && !pop_i)      count_q <= count_q + CW'(1);
      else if (pop_i && !push_i) count_q <= count_q - CW'(1);
    end
  end

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> count_q < CW'(NUM_PHYS));
  a_r2_pop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i |=> count_q == $past(count_q) - CW'(1));
  a_r8_push_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |=> count_q == $past(count_q) + CW'(1));
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int unsigned NUM_ARCH = 6,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ret_valid_i,
  input  logic [AW-1:0] ret_arch_i,
  input  logic [TW-1:0] ret_tag_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_arch_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [AW-1:0] rd_a_i,
  input  logic [AW-1:0] rd_b_i,
  output logic          valid_a_o,
  output logic [TW-1:0] tag_a_o,
  output logic          valid_b_o,
  output logic [TW-1:0] tag_b_o
);
  logic          vld_q [NUM_ARCH];
  logic [TW-1:0] tag_q [NUM_ARCH];
  logic          vld_eff [NUM_ARCH];

  // retirement clears a matching entry before the lookup sees it
  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_eff
    assign vld_eff[g] = vld_q[g] &&
      !(ret_valid_i && ret_arch_i == AW'(g) && tag_q[g] == ret_tag_i);
  end

  assign valid_a_o = vld_eff[rd_a_i];
  assign tag_a_o   = tag_q[rd_a_i];
  assign valid_b_o = vld_eff[rd_b_i];
  assign tag_b_o   = tag_q[rd_b_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        if (wr_en_i && wr_arch_i == AW'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= wr_tag_i;
        end else begin
          vld_q[i] <= vld_eff[i];
        end
      end
    end
  end

  a_r3_write_maps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_arch_i)] && tag_q[$past(wr_arch_i)] == $past(wr_tag_i));
  a_r6_clear_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && vld_q[ret_arch_i] && tag_q[ret_arch_i] == ret_tag_i &&
    !(wr_en_i && wr_arch_i == ret_arch_i) |=> !vld_q[$past(ret_arch_i)]);
  a_r7_keep_younger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && vld_q[ret_arch_i] && tag_q[ret_arch_i] != ret_tag_i &&
    !(wr_en_i && wr_arch_i == ret_arch_i)
    |=> vld_q[$past(ret_arch_i)] && tag_q[$past(ret_arch_i)] == $past(tag_q[ret_arch_i]));
endmodule

// File: rtl/rn_arch_file.sv
module rn_arch_file #(
  parameter int unsigned NUM_ARCH = 6,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW = $clog2(NUM_ARCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_a_i,
  input  logic [AW-1:0]     rd_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [DATA_W-1:0] mem_q [NUM_ARCH];

  assign rd_a_o = (wr_en_i && wr_addr_i == rd_a_i) ? wr_data_i : mem_q[rd_a_i];
  assign rd_b_o = (wr_en_i && wr_addr_i == rd_b_i) ? wr_data_i : mem_q[rd_b_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  a_r5_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS,
  parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS,
  parameter int unsigned DATA_W   = rn_pkg::XLEN,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_valid_i,
  output logic              ren_ready_o,
  input  logic [AW-1:0]     ren_src_a_i,
  input  logic [AW-1:0]     ren_src_b_i,
  input  logic [AW-1:0]     ren_dst_i,
  input  logic              ren_dst_en_i,
  output logic              src_a_mapped_o,
  output logic [TW-1:0]     src_a_tag_o,
  output logic [DATA_W-1:0] src_a_data_o,
  output logic              src_b_mapped_o,
  output logic [TW-1:0]     src_b_tag_o,
  output logic [DATA_W-1:0] src_b_data_o,
  output logic [TW-1:0]     dst_tag_o,
  input  logic              ret_valid_i,
  input  logic [AW-1:0]     ret_arch_i,
  input  logic [TW-1:0]     ret_tag_i,
  input  logic [DATA_W-1:0] ret_data_i
);
  logic pool_empty, alloc;

  assign ren_ready_o = !pool_empty;
  assign alloc       = ren_valid_i && ren_ready_o && ren_dst_en_i;

  rn_free_list #(.NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i, .rst_ni,
    .pop_i      (alloc),
    .push_i     (ret_valid_i),
    .push_tag_i (ret_tag_i),
    .head_tag_o (dst_tag_o),
    .empty_o    (pool_empty)
  );

  rn_alias_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_alias (
    .clk_i, .rst_ni,
    .ret_valid_i, .ret_arch_i, .ret_tag_i,
    .wr_en_i   (alloc),
    .wr_arch_i (ren_dst_i),
    .wr_tag_i  (dst_tag_o),
    .rd_a_i    (ren_src_a_i),
    .rd_b_i    (ren_src_b_i),
    .valid_a_o (src_a_mapped_o),
    .tag_a_o   (src_a_tag_o),
    .valid_b_o (src_b_mapped_o),
    .tag_b_o   (src_b_tag_o)
  );

  rn_arch_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W)) u_arf (
    .clk_i, .rst_ni,
    .wr_en_i   (ret_valid_i),
    .wr_addr_i (ret_arch_i),
    .wr_data_i (ret_data_i),
    .rd_a_i    (ren_src_a_i),
    .rd_b_i    (ren_src_b_i),
    .rd_a_o    (src_a_data_o),
    .rd_b_o    (src_b_data_o)
  );

  a_r9_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ready_o && !ret_valid_i |=> !ren_ready_o);
  a_r8_free_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |=> ren_ready_o);
endmodule

// File: tb/rn_rename_unit_tb.sv
module rn_rename_unit_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ren_valid, ren_ready, dst_en, ret_valid;
  logic [2:0] src_a, src_b, dst, ret_arch;
  logic [3:0] ret_tag, tag_a, tag_b, dst_tag;
  logic map_a, map_b;
  logic [31:0] data_a, data_b, ret_data;

  always #5 clk = ~clk;

  rn_rename_unit u_dut (
    .clk_i(clk), .rst_ni, .ren_valid_i(ren_valid), .ren_ready_o(ren_ready),
    .ren_src_a_i(src_a), .ren_src_b_i(src_b), .ren_dst_i(dst), .ren_dst_en_i(dst_en),
    .src_a_mapped_o(map_a), .src_a_tag_o(tag_a), .src_a_data_o(data_a),
    .src_b_mapped_o(map_b), .src_b_tag_o(tag_b), .src_b_data_o(data_b),
    .dst_tag_o(dst_tag), .ret_valid_i(ret_valid), .ret_arch_i(ret_arch),
    .ret_tag_i(ret_tag), .ret_data_i(ret_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit          m_v [6];
  logic [3:0]  m_t [6];
  logic [31:0] m_arf [6];
  logic [3:0]  m_fl [16];
  int m_head, m_tail, m_cnt;
  // in-flight writers, oldest first
  logic [2:0] q_arch [16];
  logic [3:0] q_tag [16];
  int q_h, q_t, q_n;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; ren_valid = 0; dst_en = 0; ret_valid = 0;
    src_a = 0; src_b = 0; dst = 0; ret_arch = 0; ret_tag = 0; ret_data = 0;
    for (int i = 0; i < 6; i++) begin m_v[i] = 0; m_t[i] = 0; m_arf[i] = 0; end
    for (int i = 0; i < 16; i++) m_fl[i] = 4'(i);
    m_head = 0; m_tail = 0; m_cnt = 16; q_h = 0; q_t = 0; q_n = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_cycle(input bit rv, input logic [2:0] sa, input logic [2:0] sb,
                          input logic [2:0] d, input bit den, input bit tv,
                          input logic [2:0] ra, input logic [3:0] rt, input logic [31:0] rd);
    bit e_v [6];
    logic [31:0] e_arf [6];
    bit rdy, fire;
    @(negedge clk);
    ren_valid = rv; src_a = sa; src_b = sb; dst = d; dst_en = den;
    ret_valid = tv; ret_arch = ra; ret_tag = rt; ret_data = rd;
    #1;
    for (int i = 0; i < 6; i++) begin e_v[i] = m_v[i]; e_arf[i] = m_arf[i]; end
    if (tv) begin
      e_arf[ra] = rd;
      if (m_v[ra] && m_t[ra] == rt) e_v[ra] = 0;
    end
    rdy = (m_cnt != 0);
    fire = rv && rdy;
    chk("R9 ready", 32'(ren_ready), 32'(rdy));
    chk("R3 map a", 32'(map_a), 32'(e_v[sa]));
    chk("R3 map b", 32'(map_b), 32'(e_v[sb]));
    if (e_v[sa]) chk("R3 tag a", 32'(tag_a), 32'(m_t[sa]));
    else         chk("R4 data a", data_a, e_arf[sa]);
    if (e_v[sb]) chk("R3 tag b", 32'(tag_b), 32'(m_t[sb]));
    else         chk("R4 data b", data_b, e_arf[sb]);
    if (rdy) chk("R2 dst tag", 32'(dst_tag), 32'(m_fl[m_head]));
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin m_v[i] = e_v[i]; m_arf[i] = e_arf[i]; end
    if (fire && den) begin
      m_v[d] = 1; m_t[d] = m_fl[m_head];
      q_arch[q_t] = d; q_tag[q_t] = m_fl[m_head]; q_t = (q_t + 1) % 16; q_n++;
      m_head = (m_head + 1) % 16; m_cnt--;
    end
    if (tv) begin
      m_fl[m_tail] = rt; m_tail = (m_tail + 1) % 16; m_cnt++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk); #1;
    chk("R1 ready", 32'(ren_ready), 1);
    chk("R1 first tag", 32'(dst_tag), 0);
    chk("R1 unmapped", 32'(map_a), 0);
    chk("R1 arf zero", data_a, 0);
    // R3: source equals destination sees old (unmapped) state
    do_cycle(1, 1, 2, 1, 1, 0, 0, 0, 0);
    chk("R1 alloc0", 32'(dst_tag), 0);
    do_cycle(1, 1, 2, 1, 1, 0, 0, 0, 0);
    chk("R3 old map", 32'(tag_a), 0);
    chk("R1 alloc1", 32'(dst_tag), 1);
    // R7: older writer retires, younger mapping stays
    do_cycle(1, 1, 1, 0, 0, 1, 1, 0, 32'hAAAA);
    chk("R7 kept", 32'(map_a), 1);
    chk("R7 tag", 32'(tag_a), 1);
    // R6 and R10: matching retire clears and is visible same cycle
    do_cycle(1, 1, 1, 3, 1, 1, 1, 1, 32'hBBBB);
    chk("R10 cleared", 32'(map_a), 0);
    chk("R10 bypass", data_a, 32'hBBBB);
    do_cycle(1, 1, 0, 3, 1, 0, 0, 0, 0);
    chk("R6 unmapped", 32'(map_a), 0);
    chk("R5 committed", data_a, 32'hBBBB);
    // drain: pool now 4..15 then 0,1 (R8 tail order)
    for (int k = 0; k < 14; k++) begin
      do_cycle(1, 0, 0, 4, 1, 0, 0, 0, 0);
      if (k == 12) chk("R8 tail0", 32'(dst_tag), 0);
      if (k == 13) chk("R8 tail1", 32'(dst_tag), 1);
    end
    // R9: empty pool stalls, mapping of r5 untouched
    do_cycle(1, 5, 5, 5, 1, 0, 0, 0, 0);
    chk("R9 stalled", 32'(ren_ready), 0);
    // retire frees tag 7 while still empty this cycle (R8 next-cycle)
    do_cycle(1, 5, 5, 5, 1, 1, 4, 7, 32'h1234);
    chk("R8 not same cycle", 32'(ren_ready), 0);
    do_cycle(1, 5, 4, 5, 1, 0, 0, 0, 0);
    chk("R9 r5 unmapped", 32'(map_a), 0);
    chk("R8 reuse", 32'(dst_tag), 7);
    // random in-order traffic against the model
    do_reset();
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4000; c++) begin
      bit tv, rv, den;
      logic [2:0] ra;
      logic [3:0] rt;
      tv = (q_n > 0) && ($urandom % 5 < 2);
      ra = 0; rt = 0;
      if (tv) begin
        ra = q_arch[q_h]; rt = q_tag[q_h]; q_h = (q_h + 1) % 16; q_n--;
      end
      rv = ($urandom % 10) < 7;
      den = ($urandom % 5) != 0;
      do_cycle(rv, 3'($urandom % 6), 3'($urandom % 6), 3'($urandom % 6), den,
               tv, ra, rt, $urandom);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule